// File: doc/BRIEF.md
# Paged Program Memory Address Translator

This block turns a 16-bit local processor address into an 18-bit global address for program memory. The local map has four 16 KB quarters. The lowest quarter is not program memory. The second quarter is fixed to one global page. The third quarter is a movable window whose page comes from a 4-bit page register. The top quarter is fixed to the last global page, so vectors and startup code placed there always resolve to the same location, whatever the page register holds.

Two page registers sit behind a small register bus: one for normal processor accesses and one for accesses made on behalf of debug logic. The debug register steers the window only when its enable is set and the current access comes from the debug side. While debug mode is active and the effective page is the last page, the top 256 bytes of the window are routed to a debug firmware overlay instead of flash. Translation is combinational. A register write changes translation from the next cycle on.

Top module: `paged_xlate`

## Requirements
- R1: After reset, both page registers read as 0x00, and a window access translates to page 0.
- R2: A write with `reg_sel`=0 loads `reg_wdata[3:0]` into the normal page register. Bits 7:4 are ignored. A read returns the stored value in bits 3:0, with bits 7:4 equal to zero.
- R3: A write with `reg_sel`=1 loads the debug page register the same way. It leaves the normal page register unchanged, and the reverse also holds.
- R4: A local address from 0x8000 to 0xBFFF translates to {page, addr[13:0]}, using the normal page register unless R5 selects the debug one.
- R5: The debug page register is the effective page only when both `dbg_src` and `dbg_page_en` are 1. If either one alone is set, the normal page is used.
- R6: A local address from 0xC000 to 0xFFFF translates to {4'hF, addr[13:0]} with `flash_sel`=1, for any page register value.
- R7: A local address from 0x4000 to 0x7FFF translates to {4'hD, addr[13:0]} with `flash_sel`=1.
- R8: A local address below 0x4000 gives `other_sel`=1 and `flash_sel`=0, and `glb_addr` is the local address zero-extended.
- R9: `fw_sel`=1 and `flash_sel`=0 exactly when `dbg_mode`=1, the effective page is 0xF, and the address lies in 0xBF00 to 0xBFFF. In every other case `fw_sel`=0.
- R10: In the cycle of a register write, translation still uses the old page value. The new value applies from the following cycle.
- R11: Exactly one of `flash_sel`, `other_sel` and `fw_sel` is 1 for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 normal page, 1 debug page |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register, zero-extended |
| loc_addr | input | 16 | Local access address |
| dbg_src | input | 1 | Access originates from debug logic |
| dbg_page_en | input | 1 | Debug page register enable |
| dbg_mode | input | 1 | Debug mode active |
| glb_addr | output | 18 | Translated global address |
| flash_sel | output | 1 | Access targets program flash |
| other_sel | output | 1 | Access targets non-flash space below 0x4000 |
| fw_sel | output | 1 | Access targets the debug firmware overlay |

## Verification
The bench covers the edges of the overlay: the first and last overlay bytes, the byte just below the overlay, page 0xE, debug mode off, and the top quarter while debug mode is on. A decoder that matched too wide an address range, or ignored the page or the mode, would raise `fw_sel` there or drop flash. It drives each debug qualifier alone, so a design that picked the debug page on one of them would produce a wrong page. It writes values with the upper nibble set and checks readback, which exposes a register that stores or echoes those bits. It also samples translation inside the write cycle, which catches a write path that bypasses the register.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    // Quarter of the local map, taken from the two top address bits.
    typedef enum logic [1:0] {
        RGN_LOW    = 2'b00,
        RGN_FIXED  = 2'b01,
        RGN_WINDOW = 2'b10,
        RGN_TOP    = 2'b11
    } region_e;
endpackage

// File: rtl/xlate_pagereg.sv
module xlate_pagereg #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    parameter int N_PG   = 2,
    parameter int IDX_W  = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wen,
    input  logic [IDX_W-1:0]             idx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [N_PG-1:0][PAGE_W-1:0]  pages
);
    typedef struct packed {
        logic [N_PG-1:0][PAGE_W-1:0] pg;
    } pr_state_t;

    pr_state_t st_d, st_q;
    logic      unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:PAGE_W];

    always_comb begin
        st_d = st_q;
        if (wen && (int'(idx) < N_PG)) begin
            st_d.pg[idx] = wdata[PAGE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (int'(idx) < N_PG) rdata = DATA_W'(st_q.pg[idx]);
    end

    assign pages = st_q.pg;

    for (genvar i = 0; i < N_PG; i++) begin : g_chk
        // R2 / R3: a write lands only in the addressed register.
        assert_wr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wen && int'(idx) == i) |=> (pages[i] == $past(wdata[PAGE_W-1:0])));
        assert_other_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wen && int'(idx) != i) |=> $stable(pages[i]));
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wen |=> $stable(pages));
endmodule

// File: rtl/xlate_ovl_det.sv
module xlate_ovl_det
    import xlate_pkg::*;
#(
    parameter int              LADDR_W   = 16,
    parameter int              PAGE_W    = 4,
    parameter int              OVL_LSB_W = 8,
    parameter logic [PAGE_W-1:0] OVL_PAGE = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0]  eff_pg,
    input  logic               dbg_mode,
    output logic               hit
);
    localparam int WIN_W = LADDR_W - 2;

    region_e rgn;
    logic    in_top_slice;

    assign rgn          = region_e'(addr[LADDR_W-1 -: 2]);
    assign in_top_slice = &addr[WIN_W-1:OVL_LSB_W];

    always_comb begin
        hit = 1'b0;
        if (dbg_mode && (rgn == RGN_WINDOW) && (eff_pg == OVL_PAGE) && in_top_slice) begin
            hit = 1'b1;
        end
    end

    // R9: an overlay hit needs debug mode and a window address.
    assert_ovl_needs_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (dbg_mode && addr[LADDR_W-1 -: 2] == 2'b10));
endmodule

// File: rtl/xlate_decode.sv
module xlate_decode
    import xlate_pkg::*;
#(
    parameter int                LADDR_W    = 16,
    parameter int                PAGE_W     = 4,
    parameter logic [PAGE_W-1:0] FIXED_PAGE = 'hD,
    parameter logic [PAGE_W-1:0] TOP_PAGE   = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LADDR_W-1:0]            addr,
    input  logic [PAGE_W-1:0]             eff_pg,
    input  logic                          ovl_hit,
    output logic [PAGE_W+LADDR_W-3:0]     gaddr,
    output logic                          flash,
    output logic                          other,
    output logic                          fw
);
    localparam int WIN_W = LADDR_W - 2;
    localparam int GA_W  = PAGE_W + WIN_W;

    region_e rgn;
    assign rgn = region_e'(addr[LADDR_W-1 -: 2]);

    always_comb begin
        gaddr = GA_W'(addr);
        flash = 1'b0;
        other = 1'b0;
        fw    = 1'b0;
        unique case (rgn)
            RGN_LOW: begin
                other = 1'b1;
            end
            RGN_FIXED: begin
                gaddr = {FIXED_PAGE, addr[WIN_W-1:0]};
                flash = 1'b1;
            end
            RGN_WINDOW: begin
                gaddr = {eff_pg, addr[WIN_W-1:0]};
                fw    = ovl_hit;
                flash = !ovl_hit;
            end
            RGN_TOP: begin
                gaddr = {TOP_PAGE, addr[WIN_W-1:0]};
                flash = 1'b1;
            end
        endcase
    end

    assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flash, other, fw}) == 1);
    assert_top_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[LADDR_W-1 -: 2] == 2'b11) |-> (gaddr[GA_W-1 -: PAGE_W] == TOP_PAGE && flash));
    assert_low_not_flash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[LADDR_W-1 -: 2] == 2'b00) |-> (other && !flash && !fw));
endmodule

// File: rtl/paged_xlate.sv
module paged_xlate #(
    parameter int LADDR_W   = 16,
    parameter int PAGE_W    = 4,
    parameter int DATA_W    = 8,
    parameter int OVL_LSB_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wen,
    input  logic                          reg_sel,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic [LADDR_W-1:0]            loc_addr,
    input  logic                          dbg_src,
    input  logic                          dbg_page_en,
    input  logic                          dbg_mode,
    output logic [PAGE_W+LADDR_W-3:0]     glb_addr,
    output logic                          flash_sel,
    output logic                          other_sel,
    output logic                          fw_sel
);
    localparam int N_PG    = 2;
    localparam int IDX_W   = 1;
    localparam int PG_CPU  = 0;
    localparam int PG_DBG  = 1;

    logic [N_PG-1:0][PAGE_W-1:0] pages;
    logic [PAGE_W-1:0]           eff_pg;
    logic                        use_dbg;
    logic                        ovl_hit;

    xlate_pagereg #(
        .PAGE_W(PAGE_W), .DATA_W(DATA_W), .N_PG(N_PG), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wen(reg_wen), .idx(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .pages(pages)
    );

    assign use_dbg = dbg_src && dbg_page_en;
    assign eff_pg  = use_dbg ? pages[PG_DBG] : pages[PG_CPU];

    xlate_ovl_det #(
        .LADDR_W(LADDR_W), .PAGE_W(PAGE_W), .OVL_LSB_W(OVL_LSB_W)
    ) u_ovl (
        .clk(clk), .rst_n(rst_n), .addr(loc_addr), .eff_pg(eff_pg),
        .dbg_mode(dbg_mode), .hit(ovl_hit)
    );

    xlate_decode #(
        .LADDR_W(LADDR_W), .PAGE_W(PAGE_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(loc_addr), .eff_pg(eff_pg),
        .ovl_hit(ovl_hit), .gaddr(glb_addr), .flash(flash_sel),
        .other(other_sel), .fw(fw_sel)
    );

    // R5: without both qualifiers the window follows the normal page register.
    assert_cpu_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(dbg_src && dbg_page_en) && loc_addr[LADDR_W-1 -: 2] == 2'b10)
        |-> (glb_addr[PAGE_W+LADDR_W-3 -: PAGE_W] == pages[PG_CPU]));
    // R2: readback never carries bits above the page field.
    assert_rd_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:PAGE_W] == '0);
endmodule

// File: tb/sim_paged_xlate.sv
module sim_paged_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] loc_addr = '0;
    logic        dbg_src = 1'b0;
    logic        dbg_page_en = 1'b0;
    logic        dbg_mode = 1'b0;
    logic [17:0] glb_addr;
    logic        flash_sel, other_sel, fw_sel;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    paged_xlate u0 (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .loc_addr(loc_addr),
        .dbg_src(dbg_src), .dbg_page_en(dbg_page_en), .dbg_mode(dbg_mode),
        .glb_addr(glb_addr), .flash_sel(flash_sel), .other_sel(other_sel),
        .fw_sel(fw_sel)
    );

    // {addr, src, en, mode, expected global address, flash, other, fw}
    // normal page = 0x5, debug page = 0xF when the table runs
    localparam int NV = 14;
    localparam logic [39:0] VEC [NV] = '{
        {16'h8123, 3'b000, 18'h14123, 3'b100},  // R4 plain window
        {16'hBFFF, 3'b001, 18'h17FFF, 3'b100},  // R9 page 5, no overlay
        {16'h8000, 3'b100, 18'h14000, 3'b100},  // R5 source alone
        {16'h8000, 3'b010, 18'h14000, 3'b100},  // R5 enable alone
        {16'h8000, 3'b110, 18'h3C000, 3'b100},  // R5 both -> debug page
        {16'hBF00, 3'b111, 18'h3FF00, 3'b001},  // R9 first overlay byte
        {16'hBEFF, 3'b111, 18'h3FEFF, 3'b100},  // R9 just below overlay
        {16'hBF80, 3'b110, 18'h3FF80, 3'b100},  // R9 debug mode off
        {16'hC000, 3'b000, 18'h3C000, 3'b100},  // R6 top start
        {16'hFFFF, 3'b111, 18'h3FFFF, 3'b100},  // R6 top end, no overlay
        {16'h4000, 3'b000, 18'h34000, 3'b100},  // R7 fixed start
        {16'h7ABC, 3'b000, 18'h37ABC, 3'b100},  // R7 fixed middle
        {16'h3FFF, 3'b000, 18'h03FFF, 3'b010},  // R8 low end
        {16'h0000, 3'b111, 18'h00000, 3'b010}   // R8 low start
    };
    localparam int VREQ [NV] = '{4, 9, 5, 5, 5, 9, 9, 9, 6, 6, 7, 7, 8, 8};

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic apply(input logic [15:0] a, input logic s, input logic e, input logic m);
        @(negedge clk);
        loc_addr = a; dbg_src = s; dbg_page_en = e; dbg_mode = m;
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_sel = 1'b0; #2;
        chk("R1", "cpu page readback", 32'(reg_rdata), 32'h00);
        reg_sel = 1'b1; #2;
        chk("R1", "dbg page readback", 32'(reg_rdata), 32'h00);
        apply(16'h9234, 1'b0, 1'b0, 1'b0);
        chk("R1", "window at page 0", 32'(glb_addr), 32'h01234);

        // R10 old page holds during the write cycle
        @(negedge clk);
        reg_wen = 1'b1; reg_sel = 1'b0; reg_wdata = 8'hA5; loc_addr = 16'h8000;
        #2;
        chk("R10", "translation in write cycle", 32'(glb_addr), 32'h00000);
        @(negedge clk);
        reg_wen = 1'b0; #2;
        chk("R10", "translation after write", 32'(glb_addr), 32'h14000);
        chk("R2", "upper bits dropped on readback", 32'(reg_rdata), 32'h05);

        // R3 debug register is separate
        wr(1'b1, 8'h3F);
        reg_sel = 1'b1; #2;
        chk("R3", "dbg page readback", 32'(reg_rdata), 32'h0F);
        reg_sel = 1'b0; #2;
        chk("R3", "cpu page untouched", 32'(reg_rdata), 32'h05);

        // table walk, covers R4..R9 and R11
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][39:24], VEC[i][23], VEC[i][22], VEC[i][21]);
            chk($sformatf("R%0d", VREQ[i]), $sformatf("vec %0d glb_addr", i),
                32'(glb_addr), 32'(VEC[i][20:3]));
            chk($sformatf("R%0d", VREQ[i]), $sformatf("vec %0d selects", i),
                32'({flash_sel, other_sel, fw_sel}), 32'(VEC[i][2:0]));
            chk("R11", $sformatf("vec %0d one-hot", i),
                32'(flash_sel + other_sel + fw_sel), 32'd1);
        end

        // R9 overlay through the normal page, and page 0xE misses it
        wr(1'b0, 8'h0F);
        apply(16'hBFFF, 1'b1, 1'b0, 1'b1);
        chk("R9", "overlay via cpu page F", 32'({flash_sel, other_sel, fw_sel}), 32'b001);
        wr(1'b0, 8'h0E);
        apply(16'hBF00, 1'b0, 1'b0, 1'b1);
        chk("R9", "page E no overlay", 32'({flash_sel, other_sel, fw_sel}), 32'b100);
        chk("R4", "page E window", 32'(glb_addr), 32'h3BF00);
        apply(16'hD123, 1'b0, 1'b0, 1'b0);
        chk("R6", "top independent of page E", 32'(glb_addr), 32'h3D123);
        wr(1'b1, 8'hF2);
        apply(16'h8001, 1'b1, 1'b1, 1'b0);
        chk("R3", "debug page reload", 32'(glb_addr), 32'h08001);

        // R1 reset again clears both
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_sel = 1'b0; #2;
        chk("R1", "cpu page after reset", 32'(reg_rdata), 32'h00);
        reg_sel = 1'b1; #2;
        chk("R1", "dbg page after reset", 32'(reg_rdata), 32'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule